// File: doc/BRIEF.md
# Segment Translation and Limit Unit

This block turns a segment-relative offset into a 32-bit linear address. It keeps a hidden cache of a small set of segment registers. Each cache entry holds a base, a 20-bit limit, a granularity flag and a null marker. Software-visible behaviour is driven by selector loads and by accesses.

Loads behave differently in the two modes:
- **Real mode.** A load fills the entry directly from the 16-bit segment value: the base is the value times 16 and the limit is FFFFH.
- **Protected mode.** The 16-bit value is a selector. Bits 15:3 hold the table index, bit 2 picks the local table (1) or the global table (0), and bits 1:0 hold the requested privilege.
  - The block reads the 8-byte descriptor at table base + 8 × index over a single 64-bit read port.
  - It reassembles the descriptor and stores it in the entry.
  - A global selector with index 0 marks the entry as null and reads nothing.

Accesses only use the cached entry and never touch memory. An access adds the cached base to the offset and compares the offset against the effective limit. The effective limit is the raw limit when the granularity flag is 0. When the flag is 1, it is the limit followed by twelve one bits.

Top module: `seg_xlate_unit`

## Requirements
- R1: In real mode an accepted load of value S sets the addressed entry to base S×16, limit FFFFH, granularity 0, not null. It issues no read, and ld_done pulses in the next cycle. Example: value 2000H with offset 1234H gives linear 21234H.
- R2: An access whose offset exceeds the effective limit reports fault code 01. An offset equal to the effective limit reports code 00. This applies in real mode too, where offset 10000H faults and FFFFH does not.
- R3: A protected load with a non-null selector drives rd_req high in the cycle after acceptance. It holds rd_addr stable while waiting, and rd_addr is the table base plus 8 × selector[15:3]. The table base is ltab_base when selector bit 2 is 1 and gtab_base otherwise.
- R4: A descriptor is reassembled as follows:
  - base = {d[63:56], d[39:16]}
  - limit = {d[51:48], d[15:0]}
  - granularity = d[55]

  A later access yields linear = base + offset.
- R5: With granularity 0 the limit is a byte offset, so for limit 0FFH offset 0FFH passes and 100H faults.
- R6: With granularity 1 the effective limit is {limit, FFFH}. For limit 001FFH, offset 1FFFFFH passes and 200000H faults.
- R7: The null case depends on the table bit:
  - A protected load of a selector with bits 15:2 all zero (global, index 0) issues no read, pulses ld_done in the next cycle and marks the entry null. Every later access to it reports code 10, whatever the offset.
  - Local index 0 is fetched normally.
- R8: Accesses never raise rd_req. Repeated accesses to a loaded entry return its cached translation with no table read.
- R9: Access results (ac_done, ac_lin, ac_code) appear in the cycle after ac_valid. ac_done is low otherwise. After reset every entry translates as base 0, limit FFFFH.
- R10: For a fetch, ld_done pulses in the cycle after the cycle rd_valid is seen. ld_busy is high while a fetch is outstanding, and loads offered while busy are ignored.
- R11: Fault codes are 00 ok, 01 limit, 10 null, and null takes priority over limit. ac_lin is base + offset even when a fault is reported.
- R12: A load changes only the entry it addresses.
- R13: Selector bits 1:0 do not affect the descriptor address or the cached contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_mode | input | 1 | 1 = protected interpretation of loads |
| gtab_base | input | 32 | Global descriptor table base |
| ltab_base | input | 32 | Local descriptor table base |
| ld_valid | input | 1 | Load request |
| ld_seg | input | 3 | Segment register addressed by the load |
| ld_sel | input | 16 | Segment value or selector |
| ld_busy | output | 1 | Descriptor fetch outstanding |
| ld_done | output | 1 | Load completed (one-cycle pulse) |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor byte address |
| rd_valid | input | 1 | Descriptor data valid |
| rd_data | input | 64 | Descriptor contents |
| ac_valid | input | 1 | Access request |
| ac_seg | input | 3 | Segment register used by the access |
| ac_off | input | 32 | Offset |
| ac_done | output | 1 | Access result valid |
| ac_lin | output | 32 | Linear address |
| ac_code | output | 2 | Fault code: 00 ok, 01 limit, 10 null |

## Verification
Three kinds of result have fixed latencies:
- An access result is due one cycle after ac_valid.
- A real-mode or null load completes one cycle after acceptance.
- A fetch raises rd_req one cycle after acceptance and completes one cycle after the cycle that carried rd_valid.

The bench drives every input on the falling edge and samples exactly one falling edge later for each of these latencies. It never waits open-endedly for a result. Where it checks that no read happens, it watches rd_req over the cycles in which a fetch would have started.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int LIN_W  = 32;
  localparam int LIM_W  = 20;
  localparam int SEL_W  = 16;
  localparam int DESC_W = 64;
  localparam int PAGE_BITS = 12;

  typedef struct packed {
    logic [LIN_W-1:0] base;
    logic [LIM_W-1:0] limit;
    logic             gran;
    logic             nul;
  } seg_ent_t;

  localparam logic [1:0] FC_NONE  = 2'b00;
  localparam logic [1:0] FC_LIMIT = 2'b01;
  localparam logic [1:0] FC_NULL  = 2'b10;

  function automatic seg_ent_t real_entry(input logic [SEL_W-1:0] seg);
    seg_ent_t e;
    e.base  = {{(LIN_W-SEL_W-4){1'b0}}, seg, 4'h0};
    e.limit = LIM_W'(20'h0FFFF);
    e.gran  = 1'b0;
    e.nul   = 1'b0;
    return e;
  endfunction

  function automatic seg_ent_t null_entry();
    seg_ent_t e;
    e = '0;
    e.nul = 1'b1;
    return e;
  endfunction

  function automatic seg_ent_t desc_entry(input logic [DESC_W-1:0] d);
    seg_ent_t e;
    e.base  = {d[63:56], d[39:16]};
    e.limit = {d[51:48], d[15:0]};
    e.gran  = d[55];
    e.nul   = 1'b0;
    return e;
  endfunction

  function automatic logic [LIN_W-1:0] eff_limit(input logic [LIM_W-1:0] lim,
                                                  input logic g);
    return g ? {lim, {PAGE_BITS{1'b1}}} : {{PAGE_BITS{1'b0}}, lim};
  endfunction

  function automatic logic sel_is_gnull(input logic [SEL_W-1:0] sel);
    return sel[SEL_W-1:2] == '0;
  endfunction

  function automatic logic [LIN_W-1:0] desc_addr(input logic [LIN_W-1:0] gbase,
                                                  input logic [LIN_W-1:0] lbase,
                                                  input logic [SEL_W-1:0] sel);
    logic [LIN_W-1:0] tb;
    tb = sel[2] ? lbase : gbase;
    return tb + {{(LIN_W-SEL_W){1'b0}}, sel[SEL_W-1:3], 3'b000};
  endfunction
endpackage

// File: rtl/segx_fetch.sv
module segx_fetch
  import segx_pkg::*;
#(
  parameter int SEG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_mode,
  input  logic [LIN_W-1:0]  gtab_base,
  input  logic [LIN_W-1:0]  ltab_base,
  input  logic              ld_valid,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [SEL_W-1:0]  ld_sel,
  output logic              ld_busy,
  output logic              ld_done,
  output logic              rd_req,
  output logic [LIN_W-1:0]  rd_addr,
  input  logic              rd_valid,
  input  logic [DESC_W-1:0] rd_data,
  output logic              wr_en,
  output logic [SEG_W-1:0]  wr_seg,
  output seg_ent_t          wr_ent
);
  typedef enum logic {S_IDLE, S_FETCH} fst_e;
  fst_e             state_q;
  logic [SEG_W-1:0] pend_seg_q;

  logic ld_accept, take_real, take_null, start_fetch, fetch_ret;

  assign ld_accept   = ld_valid && (state_q == S_IDLE);
  assign take_real   = ld_accept && !prot_mode;
  assign take_null   = ld_accept && prot_mode && sel_is_gnull(ld_sel);
  assign start_fetch = ld_accept && prot_mode && !sel_is_gnull(ld_sel);
  assign fetch_ret   = (state_q == S_FETCH) && rd_valid;

  always_comb begin
    wr_en  = take_real || take_null || fetch_ret;
    wr_seg = fetch_ret ? pend_seg_q : ld_seg;
    if (fetch_ret)      wr_ent = desc_entry(rd_data);
    else if (take_null) wr_ent = null_entry();
    else                wr_ent = real_entry(ld_sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      pend_seg_q <= '0;
      rd_addr    <= '0;
      ld_done    <= 1'b0;
    end else begin
      ld_done <= wr_en;
      if (start_fetch) begin
        state_q    <= S_FETCH;
        pend_seg_q <= ld_seg;
        rd_addr    <= desc_addr(gtab_base, ltab_base, ld_sel);
      end else if (fetch_ret) begin
        state_q <= S_IDLE;
      end
    end
  end

  assign rd_req  = (state_q == S_FETCH);
  assign ld_busy = (state_q == S_FETCH);

  p_real_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_real |=> !rd_req);
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
  p_null_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_null |=> (!rd_req && ld_done));
  p_done_after_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ret |=> (ld_done && !ld_busy));
endmodule

// File: rtl/segx_cache.sv
module segx_cache
  import segx_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEG_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  seg_ent_t         wr_ent,
  input  logic [SEG_W-1:0] rd_seg,
  output seg_ent_t         rd_ent
);
  seg_ent_t ent_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_seg == SEG_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   ent_q[g] <= real_entry('0);
      else if (hit) ent_q[g] <= wr_ent;
    end
  end

  always_comb begin
    rd_ent = real_entry('0);
    for (int i = 0; i < NUM_SEG; i++)
      if (rd_seg == SEG_W'(i)) rd_ent = ent_q[i];
  end
endmodule

// File: rtl/segx_access.sv
module segx_access
  import segx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ac_valid,
  input  seg_ent_t         ent,
  input  logic [LIN_W-1:0] ac_off,
  output logic             ac_done,
  output logic [LIN_W-1:0] ac_lin,
  output logic [1:0]       ac_code
);
  logic [LIN_W-1:0] lim_eff, lin_sum;
  logic             over_limit;
  logic [1:0]       code_nxt;

  assign lim_eff    = eff_limit(ent.limit, ent.gran);
  assign over_limit = ac_off > lim_eff;
  assign lin_sum    = ent.base + ac_off;
  assign code_nxt   = ent.nul ? FC_NULL : (over_limit ? FC_LIMIT : FC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_done <= 1'b0;
      ac_lin  <= '0;
      ac_code <= FC_NONE;
    end else begin
      ac_done <= ac_valid;
      if (ac_valid) begin
        ac_lin  <= lin_sum;
        ac_code <= code_nxt;
      end
    end
  end

  p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ac_valid |=> ac_done);
  p_no_spurious_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_valid |=> !ac_done);
  p_code_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ac_done |-> (ac_code != 2'b11));
  p_null_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_valid && ent.nul) |=> (ac_code == FC_NULL));
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import segx_pkg::*;
#(
  parameter int NUM_SEG = 6,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_mode,
  input  logic [31:0]       gtab_base,
  input  logic [31:0]       ltab_base,
  input  logic              ld_valid,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [15:0]       ld_sel,
  output logic              ld_busy,
  output logic              ld_done,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  input  logic              rd_valid,
  input  logic [63:0]       rd_data,
  input  logic              ac_valid,
  input  logic [SEG_W-1:0]  ac_seg,
  input  logic [31:0]       ac_off,
  output logic              ac_done,
  output logic [31:0]       ac_lin,
  output logic [1:0]        ac_code
);
  logic             wr_en;
  logic [SEG_W-1:0] wr_seg;
  seg_ent_t         wr_ent, rd_ent;

  segx_fetch #(.SEG_W(SEG_W)) u_fetch (
    .clk, .rst_n, .prot_mode, .gtab_base, .ltab_base,
    .ld_valid, .ld_seg, .ld_sel, .ld_busy, .ld_done,
    .rd_req, .rd_addr, .rd_valid, .rd_data,
    .wr_en, .wr_seg, .wr_ent
  );

  segx_cache #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_cache (
    .clk, .rst_n, .wr_en, .wr_seg, .wr_ent,
    .rd_seg(ac_seg), .rd_ent
  );

  segx_access u_access (
    .clk, .rst_n, .ac_valid, .ent(rd_ent), .ac_off,
    .ac_done, .ac_lin, .ac_code
  );

  p_read_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ld_busy);
endmodule

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
  logic        clk = 0, rst_n = 0;
  logic        prot_mode = 0;
  logic [31:0] gtab_base = 32'h0001_0000, ltab_base = 32'h0002_0000;
  logic        ld_valid = 0;
  logic [2:0]  ld_seg = 0;
  logic [15:0] ld_sel = 0;
  logic        ld_busy, ld_done, rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid = 0;
  logic [63:0] rd_data = 0;
  logic        ac_valid = 0;
  logic [2:0]  ac_seg = 0;
  logic [31:0] ac_off = 0;
  logic        ac_done;
  logic [31:0] ac_lin;
  logic [1:0]  ac_code;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  seg_xlate_unit i_seg_xlate_unit (.*);

  function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [19:0] l,
                                          input logic g);
    return {b[31:24], g, 3'b100, l[19:16], 8'h92, b[23:0], l[15:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input string req, input logic [2:0] s, input logic [31:0] off,
                        input logic [31:0] exp_lin, input logic [1:0] exp_code);
    ac_valid = 1; ac_seg = s; ac_off = off;
    @(negedge clk);
    ac_valid = 0;
    chk({req, " done"}, ac_done, 1);
    chk({req, " lin"}, ac_lin, exp_lin);
    chk({req, " code"}, ac_code, exp_code);
    chk({req, " no read"}, rd_req, 0);
    @(negedge clk);
    chk({req, " done low"}, ac_done, 0);
  endtask

  // load with no memory read expected (real mode or global null)
  task automatic load_direct(input string req, input logic [2:0] s, input logic [15:0] sel);
    ld_valid = 1; ld_seg = s; ld_sel = sel;
    @(negedge clk);
    ld_valid = 0;
    chk({req, " done"}, ld_done, 1);
    chk({req, " no read"}, rd_req, 0);
    @(negedge clk);
  endtask

  task automatic load_fetch(input string req, input logic [2:0] s, input logic [15:0] sel,
                            input logic [31:0] exp_addr, input logic [63:0] desc);
    ld_valid = 1; ld_seg = s; ld_sel = sel;
    @(negedge clk);
    ld_valid = 0;
    chk({req, " rd_req"}, rd_req, 1);
    chk({req, " rd_addr"}, rd_addr, exp_addr);
    chk({req, " busy"}, ld_busy, 1);
    @(negedge clk);
    chk({req, " addr held"}, rd_addr, exp_addr);
    rd_valid = 1; rd_data = desc;
    @(negedge clk);
    rd_valid = 0;
    chk({req, " done"}, ld_done, 1);
    chk({req, " idle"}, rd_req, 0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 reset ac_done", ac_done, 0);
    chk("R10 reset busy", ld_busy, 0);
    chk("R8 reset rd_req", rd_req, 0);
    access("R9 reset entry", 3'd5, 32'h0000_ABCD, 32'h0000_ABCD, 2'b00);
  endtask

  task automatic t_real;
    prot_mode = 0;
    load_direct("R1 real load", 3'd3, 16'h2000);
    access("R1 real xlate", 3'd3, 32'h1234, 32'h0002_1234, 2'b00);
    access("R2 real at limit", 3'd3, 32'hFFFF, 32'h0002_FFFF, 2'b00);
    access("R2 real over limit", 3'd3, 32'h1_0000, 32'h0003_0000, 2'b01);
  endtask

  task automatic t_prot_byte;
    prot_mode = 1;
    load_fetch("R3 global fetch", 3'd1, 16'h0008, 32'h0001_0008,
               mk_desc(32'h0010_0000, 20'h000FF, 1'b0));
    access("R4 R5 at limit", 3'd1, 32'hFF, 32'h0010_00FF, 2'b00);
    access("R5 over limit", 3'd1, 32'h100, 32'h0010_0100, 2'b01);
  endtask

  task automatic t_prot_page;
    prot_mode = 1;
    load_fetch("R3 local fetch", 3'd2, 16'h0014, 32'h0002_0010,
               mk_desc(32'h1000_0000, 20'h001FF, 1'b1));
    access("R6 page limit", 3'd2, 32'h001F_FFFF, 32'h101F_FFFF, 2'b00);
    access("R6 page over", 3'd2, 32'h0020_0000, 32'h1020_0000, 2'b01);
    access("R4 split base", 3'd2, 32'h10, 32'h1000_0010, 2'b00);
  endtask

  task automatic t_null;
    prot_mode = 1;
    load_direct("R7 global null", 3'd0, 16'h0003);
    access("R7 null access", 3'd0, 32'h0, 32'h0, 2'b10);
    access("R11 null beats limit", 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b10);
    load_fetch("R7 local index0 fetched", 3'd0, 16'h0004, 32'h0002_0000,
               mk_desc(32'h0000_5000, 20'h00010, 1'b0));
    access("R7 local0 usable", 3'd0, 32'h10, 32'h0000_5010, 2'b00);
  endtask

  task automatic t_rpl;
    prot_mode = 1;
    load_fetch("R13 rpl ignored addr", 3'd4, 16'h000B, 32'h0001_0008,
               mk_desc(32'h0010_0000, 20'h000FF, 1'b0));
    access("R13 rpl ignored entry", 3'd4, 32'h20, 32'h0010_0020, 2'b00);
  endtask

  task automatic t_indep;
    access("R12 seg3 untouched", 3'd3, 32'h1234, 32'h0002_1234, 2'b00);
    access("R8 cached repeat a", 3'd1, 32'h1, 32'h0010_0001, 2'b00);
    access("R8 cached repeat b", 3'd1, 32'h2, 32'h0010_0002, 2'b00);
  endtask

  task automatic t_busy_ignore;
    prot_mode = 1;
    ld_valid = 1; ld_seg = 3'd1; ld_sel = 16'h0010;
    @(negedge clk);
    ld_seg = 3'd5; ld_sel = 16'h0000;   // offered while busy: global null to seg 5
    chk("R10 busy", ld_busy, 1);
    @(negedge clk);
    ld_valid = 0;
    chk("R10 addr", rd_addr, 32'h0001_0010);
    rd_valid = 1; rd_data = mk_desc(32'h0030_0000, 20'h0FFFF, 1'b0);
    @(negedge clk);
    rd_valid = 0;
    chk("R10 done after data", ld_done, 1);
    @(negedge clk);
    chk("R10 no extra done", ld_done, 0);
    access("R10 ignored load left seg5", 3'd5, 32'h44, 32'h0000_0044, 2'b00);
    access("R10 fetched seg1", 3'd1, 32'h44, 32'h0030_0044, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_real();
    t_prot_byte();
    t_prot_page();
    t_null();
    t_rpl();
    t_indep();
    t_busy_ignore();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule